// File: doc/BRIEF.md
# Half-Symbol Correlation Fractional Frequency Offset Estimator

The block takes one 512-sample complex preamble, streamed as signed Q7.8 pairs. It correlates the first half of the preamble with the second half and reports the phase of that correlation as a fraction of pi. The offset-to-phase mapping is fixed, so downstream logic can turn the phase into a fractional carrier frequency offset. Each input sample is multiplied by the conjugate of the sample 256 positions later, and the 256 products are summed into a wide complex accumulator.

The angle is not computed with a rotation engine or a two-argument arctangent. The correlation vector is first folded into the first octant using the signs of its components and a swap of the larger and smaller magnitudes. The sine of the folded angle is then quantized to an 11-bit index by an 11-step successive-approximation search that needs no divider or square root. That index addresses a 2048-entry arcsine table. The full-circle angle is rebuilt from the fold decisions. Frames may arrive back to back, and idle cycles inside a frame are allowed.

Top module: `frac_cfo_est`

## Requirements
- R1: With c = sum over n = 0..255 of x[n]*conj(x[n+256]), where x[n] is the n-th accepted sample, the reported angle is the angle of c. The first accepted sample after reset, or after a completed frame, is x[0].
- R2: angleOut is a 16-bit two's-complement value in which 32768 counts stand for pi, so 16384 is pi/2. A correlation on the negative real axis reads -32768. The result is within 2 counts of the table-based value defined by R3 and R4.
- R3: Table entry i (0..2047) holds round(asin(i*sin(pi/4)/2048)/pi*32768), which lies in [0, 8192). The index used is the largest i with i*sin(pi/4)/2048 <= s/sqrt(s^2+b^2), where s and b are the smaller and larger of |Re c| and |Im c|.
- R4: With t the table value, the angle is built in this order: t becomes 16384 - t when |Im c| > |Re c|; the result becomes 32768 minus itself when Re c < 0; the result is negated when Im c < 0. All steps use modulo-65536 arithmetic.
- R5: When |Re c| equals |Im c|, the index saturates at 2047 and no swap is applied.
- R6: When c is exactly zero, angleOut is 0 and zeroFlag is 1. Otherwise zeroFlag is 0.
- R7: outValid is high for exactly one cycle, after the 14th rising edge that follows the edge accepting the 512th sample of a frame. At no other time is it high.
- R8: A cycle with inValid low accepts no sample. Its inRe and inIm values have no effect on any result.
- R9: The first sample of the next frame may be accepted on the edge right after the 512th sample, and both frames are reported correctly.
- R10: After reset, outValid is 0, angleOut is 0 and zeroFlag is 0, and the next accepted sample is x[0].
- R11: angleOut and zeroFlag change only together with an outValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Sample strobe; inRe and inIm are taken when high |
| inRe | input | 16 | Real part of the sample, signed Q7.8 |
| inIm | input | 16 | Imaginary part of the sample, signed Q7.8 |
| outValid | output | 1 | One-cycle pulse marking a new estimate |
| angleOut | output | 16 | Correlation angle, signed, 32768 counts = pi |
| zeroFlag | output | 1 | The last estimate came from an all-zero correlation |

## Verification
The estimate of a frame is due after the 14th rising edge following the edge that accepts its final sample. The bench model counts accepted samples at each rising edge and, once a frame is complete, counts edges. It then expects outValid high exactly at the falling edge where that count reaches 14. Outputs are compared at every falling edge: outValid against the model, the angle and flag against the model's table-based value in the pulse cycle, and the held values in every other cycle.

// File: rtl/frac_cfo_pkg.sv
package frac_cfo_pkg;
  localparam int HALF_AW = 8;
  localparam int HALF_N  = 1 << HALF_AW;
  localparam int IDX_W   = 11;
  localparam int BIT_W   = $clog2(IDX_W);
  localparam int LAT     = IDX_W + 3;

  typedef enum logic [2:0] {ST_IDLE, ST_ABS, ST_NORM, ST_SRCH, ST_OUT} phase_t;

  typedef struct packed {
    logic               wrBuf;
    logic               accLoad;
    logic               accAdd;
    logic [HALF_AW-1:0] addr;
    logic               doAbs;
    logic               doNorm;
    logic               doSrch;
    logic [BIT_W-1:0]   srchBit;
    logic               doOut;
  } ctl_t;
endpackage

// File: rtl/frac_cfo_ctrl.sv
module frac_cfo_ctrl
  import frac_cfo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  output ctl_t ctl,
  output logic outValid
);
  logic [HALF_AW:0] pos;
  phase_t           st;
  logic [BIT_W-1:0] bitCnt;
  logic             lastSample;

  assign lastSample = inValid && (pos == {(HALF_AW+1){1'b1}});

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (inValid) pos <= pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitCnt   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= (st == ST_OUT);
      case (st)
        ST_IDLE: if (lastSample) st <= ST_ABS;
        ST_ABS:  st <= ST_NORM;
        ST_NORM: begin
          st     <= ST_SRCH;
          bitCnt <= BIT_W'(IDX_W - 1);
        end
        ST_SRCH: begin
          if (bitCnt == '0) st <= ST_OUT;
          else bitCnt <= bitCnt - 1'b1;
        end
        ST_OUT:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.wrBuf   = inValid && !pos[HALF_AW];
    ctl.accLoad = inValid && pos[HALF_AW] && (pos[HALF_AW-1:0] == '0);
    ctl.accAdd  = inValid && pos[HALF_AW] && (pos[HALF_AW-1:0] != '0);
    ctl.addr    = pos[HALF_AW-1:0];
    ctl.doAbs   = (st == ST_ABS);
    ctl.doNorm  = (st == ST_NORM);
    ctl.doSrch  = (st == ST_SRCH);
    ctl.srchBit = bitCnt;
    ctl.doOut   = (st == ST_OUT);
  end
endmodule

// File: rtl/frac_cfo_dp.sv
module frac_cfo_dp
  import frac_cfo_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctl_t                 ctl,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic signed [AW-1:0] angleOut,
  output logic                 zeroFlag
);
  localparam int PW   = 2 * DW + 1;
  localparam int ACCW = PW + HALF_AW;
  localparam int MW   = ACCW;
  localparam int NW   = 20;
  localparam int SQ   = 2 * NW;
  localparam int CW   = 2 * IDX_W + SQ + 1;
  localparam int TW   = AW - 2;
  localparam int TBL  = 1 << IDX_W;
  localparam real PI_R = 3.14159265358979323846;

  // first-half sample store
  logic [2*DW-1:0] mem [HALF_N];
  logic [2*DW-1:0] rd;
  always_ff @(posedge clk) begin
    if (ctl.wrBuf) mem[ctl.addr] <= {inRe, inIm};
  end
  assign rd = mem[ctl.addr];

  logic signed [DW-1:0] aRe, aIm;
  logic signed [PW-1:0] pRe, pIm;
  assign aRe = rd[2*DW-1:DW];
  assign aIm = rd[DW-1:0];
  // a * conj(b)
  assign pRe = PW'(aRe) * PW'(inRe) + PW'(aIm) * PW'(inIm);
  assign pIm = PW'(aIm) * PW'(inRe) - PW'(aRe) * PW'(inIm);

  logic signed [ACCW-1:0] accRe, accIm;
  always_ff @(posedge clk) begin
    if (rst) begin
      accRe <= '0;
      accIm <= '0;
    end else if (ctl.accLoad) begin
      accRe <= ACCW'(pRe);
      accIm <= ACCW'(pIm);
    end else if (ctl.accAdd) begin
      accRe <= accRe + ACCW'(pRe);
      accIm <= accIm + ACCW'(pIm);
    end
  end

  // octant fold
  logic [MW-1:0] absRe, absIm, bigR, smallR;
  logic          negRe, negIm, swapR, zeroR;
  assign absRe = accRe[ACCW-1] ? MW'(-accRe) : MW'(accRe);
  assign absIm = accIm[ACCW-1] ? MW'(-accIm) : MW'(accIm);

  always_ff @(posedge clk) begin
    if (rst) begin
      bigR <= '0; smallR <= '0;
      negRe <= 1'b0; negIm <= 1'b0; swapR <= 1'b0; zeroR <= 1'b0;
    end else if (ctl.doAbs) begin
      negRe  <= accRe[ACCW-1];
      negIm  <= accIm[ACCW-1];
      swapR  <= absIm > absRe;
      zeroR  <= (absRe == '0) && (absIm == '0);
      bigR   <= (absIm > absRe) ? absIm : absRe;
      smallR <= (absIm > absRe) ? absRe : absIm;
    end
  end

  // normalize so the larger magnitude fits NW bits
  int msbPos, shAmt;
  always_comb begin
    msbPos = 0;
    for (int i = 0; i < MW; i++) begin
      if (bigR[i]) msbPos = i;
    end
    shAmt = (msbPos > NW - 1) ? msbPos - (NW - 1) : 0;
  end

  logic [NW-1:0] bN, sN;
  always_ff @(posedge clk) begin
    if (rst) begin
      bN <= '0; sN <= '0;
    end else if (ctl.doNorm) begin
      bN <= NW'(bigR >> shAmt);
      sN <= NW'(smallR >> shAmt);
    end
  end

  // successive approximation of the sine index
  logic [IDX_W-1:0]   idx, trial;
  logic [2*IDX_W-1:0] trialSq;
  logic [SQ-1:0]      bSq, sSq;
  logic [SQ:0]        magSq;
  logic [CW-1:0]      lhs, rhs;

  assign trial   = idx | (IDX_W'(1) << ctl.srchBit);
  assign trialSq = (2*IDX_W)'(trial) * (2*IDX_W)'(trial);
  assign bSq     = SQ'(bN) * SQ'(bN);
  assign sSq     = SQ'(sN) * SQ'(sN);
  assign magSq   = (SQ+1)'(bSq) + (SQ+1)'(sSq);
  assign lhs     = CW'(trialSq) * CW'(magSq);
  assign rhs     = CW'(sSq) << (2 * IDX_W + 1);

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (ctl.doNorm) idx <= '0;
    else if (ctl.doSrch && (lhs <= rhs)) idx <= trial;
  end

  // arcsine table, values in units of pi
  logic [TW-1:0] rom [TBL];
  for (genvar g = 0; g < TBL; g++) begin : g_rom
    localparam real SV = real'(g) / real'(TBL) * $sqrt(0.5);
    localparam real AV = $asin(SV) / PI_R * real'(1 << (AW - 1));
    assign rom[g] = TW'($rtoi(AV + 0.5));
  end

  logic [AW-1:0] tVal, a1, a2, a3;
  always_comb begin
    tVal = AW'(rom[idx]);
    a1   = swapR ? (AW'(1 << (AW - 2)) - tVal) : tVal;
    a2   = negRe ? (AW'(1 << (AW - 1)) - a1) : a1;
    a3   = negIm ? (AW'(0) - a2) : a2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      angleOut <= '0;
      zeroFlag <= 1'b0;
    end else if (ctl.doOut) begin
      angleOut <= zeroR ? '0 : a3;
      zeroFlag <= zeroR;
    end
  end
endmodule

// File: rtl/frac_cfo_est.sv
module frac_cfo_est
  import frac_cfo_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic                 outValid,
  output logic signed [AW-1:0] angleOut,
  output logic                 zeroFlag
);
  ctl_t ctl;

  frac_cfo_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  frac_cfo_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .inRe     (inRe),
    .inIm     (inIm),
    .angleOut (angleOut),
    .zeroFlag (zeroFlag)
  );
endmodule

// File: rtl/frac_cfo_chk.sv
module frac_cfo_chk
  import frac_cfo_pkg::*;
#(
  parameter int AW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic                 outValid,
  input logic signed [AW-1:0] angleOut,
  input logic                 zeroFlag
);
  localparam int DLW = $clog2(LAT + 2);

  logic [HALF_AW:0] cnt;
  logic [DLW-1:0]   dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dly <= '0;
    end else begin
      if (inValid) cnt <= cnt + 1'b1;
      if (inValid && (&cnt)) dly <= DLW'(1);
      else if (dly == DLW'(LAT + 1)) dly <= '0;
      else if (dly != '0) dly <= dly + 1'b1;
    end
  end

  // R7: pulse lands exactly LAT edges after the final sample
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    outValid == (dly == DLW'(LAT + 1)));

  // R7: single-cycle pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R11: results held between pulses
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(angleOut) && $stable(zeroFlag)));

  // R6: zero correlation reports angle zero
  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    zeroFlag |-> (angleOut == '0));

  // R10: reset values
  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && (angleOut == '0) && !zeroFlag));
endmodule

bind frac_cfo_est frac_cfo_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_frac_cfo_est.sv
`timescale 1ns/1ps
module sim_frac_cfo_est;
  localparam int NS  = 512;
  localparam int HN  = 256;
  localparam int LATE = 14;
  localparam int TOL = 2;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [15:0] inRe = '0, inIm = '0;
  logic outValid;
  logic signed [15:0] angleOut;
  logic zeroFlag;

  always #4 clk = ~clk;

  frac_cfo_est u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .angleOut(angleOut), .zeroFlag(zeroFlag)
  );

  int nChk = 0, nBad = 0;
  string curTag = "R2", expTag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  function automatic int refAngle(input longint cr, input longint ci);
    longint ax, ay;
    bit sw;
    real b, s, r;
    int idx, t, a;
    if (cr == 0 && ci == 0) return 0;
    ax = (cr < 0) ? -cr : cr;
    ay = (ci < 0) ? -ci : ci;
    sw = ay > ax;
    b = sw ? real'(ay) : real'(ax);
    s = sw ? real'(ax) : real'(ay);
    r = s / $sqrt(s * s + b * b);
    idx = $rtoi($floor(r / $sqrt(0.5) * 2048.0));
    if (idx > 2047) idx = 2047;
    t = $rtoi($asin(real'(idx) / 2048.0 * $sqrt(0.5)) / PI * 32768.0 + 0.5);
    a = sw ? 16384 - t : t;
    if (cr < 0) a = 32768 - a;
    if (ci < 0) a = -a;
    a = a & 65535;
    if (a >= 32768) a = a - 65536;
    return a;
  endfunction

  // behavioural reference
  int mRe[NS], mIm[NS];
  int mPos = 0, dlyM = 0;
  bit pend = 1'b0;
  int expAng = 0;
  bit expZero = 1'b0;
  int lastAng = 0;
  bit lastZero = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      mPos = 0; pend = 1'b0; dlyM = 0;
    end else begin
      if (pend) dlyM++;
      if (inValid) begin
        mRe[mPos] = int'(inRe);
        mIm[mPos] = int'(inIm);
        mPos++;
        if (mPos == NS) begin
          longint cr, ci;
          cr = 0; ci = 0;
          for (int n = 0; n < HN; n++) begin
            cr += longint'(mRe[n]) * mRe[n+HN] + longint'(mIm[n]) * mIm[n+HN];
            ci += longint'(mIm[n]) * mRe[n+HN] - longint'(mRe[n]) * mIm[n+HN];
          end
          expAng  = refAngle(cr, ci);
          expZero = (cr == 0) && (ci == 0);
          expTag  = curTag;
          mPos = 0; pend = 1'b1; dlyM = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit expV;
      int d;
      expV = pend && (dlyM == LATE);
      chk(outValid == expV, "R7", "outValid", int'(outValid), int'(expV));
      if (expV) begin
        d = (int'(angleOut) - expAng) & 65535;
        if (d >= 32768) d = d - 65536;
        chk((d <= TOL) && (d >= -TOL), expTag, "angle", int'(angleOut), expAng);
        chk(zeroFlag == expZero, "R6", "zeroFlag", int'(zeroFlag), int'(expZero));
        lastAng = int'(angleOut);
        lastZero = zeroFlag;
        pend = 1'b0;
      end else begin
        chk(int'(angleOut) == lastAng, "R11", "held angle", int'(angleOut), lastAng);
        chk(zeroFlag == lastZero, "R11", "held flag", int'(zeroFlag), int'(lastZero));
      end
    end
  end

  int fRe[NS], fIm[NS];

  task automatic fillConst(input int r1, input int i1, input int r2, input int i2);
    for (int n = 0; n < NS; n++) begin
      fRe[n] = (n < HN) ? r1 : r2;
      fIm[n] = (n < HN) ? i1 : i2;
    end
  endtask

  task automatic fillRand(input int span);
    for (int n = 0; n < NS; n++) begin
      fRe[n] = int'($urandom_range(2 * span)) - span;
      fIm[n] = int'($urandom_range(2 * span)) - span;
    end
  endtask

  task automatic driveCycle(input bit v, input int r, input int i);
    inValid = v;
    inRe = 16'(r);
    inIm = 16'(i);
    @(negedge clk);
  endtask

  task automatic sendFrame(input bit gaps, input int idleAfter);
    for (int n = 0; n < NS; n++) begin
      if (gaps && ($urandom_range(3) == 0))
        driveCycle(1'b0, int'($urandom_range(60000)) - 30000, int'($urandom_range(60000)) - 30000);
      driveCycle(1'b1, fRe[n], fIm[n]);
    end
    for (int k = 0; k < idleAfter; k++)
      driveCycle(1'b0, int'($urandom_range(1000)), int'($urandom_range(1000)));
  endtask

  initial begin
    int oRe[8] = '{200, 50, -50, -200, -200, -50, 50, 200};
    int oIm[8] = '{-50, -200, -200, -50, 50, 200, 200, 50};
    int keepRe[NS], keepIm[NS];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(outValid == 1'b0, "R10", "outValid after reset", int'(outValid), 0);
    chk(angleOut == 16'sd0, "R10", "angle after reset", int'(angleOut), 0);
    chk(zeroFlag == 1'b0, "R10", "flag after reset", int'(zeroFlag), 0);

    curTag = "R2"; fillConst(300, 0, 300, 0); sendFrame(1'b0, 20);
    // R4: one frame per octant
    curTag = "R4";
    for (int k = 0; k < 8; k++) begin
      fillConst(300, 0, oRe[k], oIm[k]);
      sendFrame(1'b0, 20);
    end
    // R2: axes, including pi
    curTag = "R2";
    fillConst(300, 0, -100, 0); sendFrame(1'b0, 20);
    fillConst(300, 0, 0, -100); sendFrame(1'b0, 20);
    fillConst(300, 0, 0, 100);  sendFrame(1'b0, 20);
    // R5: equal magnitudes
    curTag = "R5";
    fillConst(300, 0, 100, -100); sendFrame(1'b0, 20);
    fillConst(300, 0, -100, 100); sendFrame(1'b0, 20);
    // R3: small first-octant angle
    curTag = "R3";
    fillConst(1000, 0, 1000, -7); sendFrame(1'b0, 20);
    // R6: zero correlations
    curTag = "R6";
    fillConst(0, 0, 0, 0);     sendFrame(1'b0, 20);
    fillConst(0, 0, 500, 700); sendFrame(1'b0, 20);
    // R1: random and full-scale data
    curTag = "R1";
    fillRand(2000);  sendFrame(1'b0, 20);
    fillRand(32767); sendFrame(1'b0, 20);
    // R8: same content with idle gaps carrying junk
    curTag = "R8";
    fillRand(3000);
    for (int n = 0; n < NS; n++) begin keepRe[n] = fRe[n]; keepIm[n] = fIm[n]; end
    sendFrame(1'b0, 20);
    for (int n = 0; n < NS; n++) begin fRe[n] = keepRe[n]; fIm[n] = keepIm[n]; end
    sendFrame(1'b1, 20);
    // R9: frames back to back
    curTag = "R9";
    fillRand(1500); sendFrame(1'b0, 0);
    fillConst(-400, 250, 120, 90); sendFrame(1'b0, 0);
    fillRand(800); sendFrame(1'b0, 30);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R7 watchdog expired got=0 exp=1");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule